// File: doc/BRIEF.md
# MDIO Management Register-Access Controller

This block is a management-bus master for Ethernet PHYs. Software talks to it through two 32-bit registers. The control register enables the block and sets the MDC clock divider, and it reports whether the engine is idle. The access register takes a single command word that holds a start flag, a read/write select, a PHY address, a register address and write data.

Writing the access register with the start flag set launches one Clause-22 management frame on MDC/MDIO. The start flag then reads back as set until the frame is finished and clears itself. After a read, the access register holds the returned data and an acknowledge flag, which shows whether a PHY answered.

MDIO is driven on the falling edge of MDC and sampled on the rising edge. During the turnaround and data bits of a read, the master releases the line. The MDC frequency is the system clock divided by 2 × (divider + 1).

Top module: `mdio_access_ctrl`

## Requirements
- R1: After reset the access register reads 0, the control register reads 0x8000_0000 (idle bit 31 set, enable bit 30 clear, divider 0), and MDC and the MDIO output enable are low.
- R2: While enable (control bit 30) is set, MDC has a period of 2 × (divider + 1) system clocks, where the divider is control bits DIV_W-1:0. While enable is clear, MDC is held low.
- R3: An access-register write with bit 31 (GO) set starts a transaction. GO reads 1 and the idle bit (control bit 31) reads 0 until the frame completes. Then GO clears by itself and the idle bit returns to 1.
- R4: A write command (bit 30 = 1) sends 64 driven bits, MSB first, in this order: 32 ones, start 01, opcode 01, PHY address (bits 20:16), register address (bits 25:21), turnaround 10, then data bits 15:0.
- R5: A read command (bit 30 = 0) drives 32 ones, start 01, opcode 10, PHY address and register address. It then holds the MDIO output enable low for the two turnaround bits and the 16 data bits.
- R6: A read sets ACK (access bit 29) only when the second turnaround bit is sampled low. In that case access bits 15:0 hold the 16 data bits sampled MSB first. A read that no PHY answers leaves ACK at 0.
- R7: A write to the access register while GO is set is ignored. The fields in progress and the frame on the wire are unchanged, and no further frame follows.
- R8: A command issued while enable is clear stays pending, with GO set and the idle bit clear, and sends no frame. The frame starts once enable is set.
- R9: Any accepted access-register write clears ACK. A completed write command leaves ACK at 0 and the written data in bits 15:0.
- R10: The driven MDIO value changes only at a falling edge of MDC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_sel | input | 1 | Register select: 0 control, 1 access |
| bus_wdata | input | 32 | Register write data |
| ctrl_rdata | output | 32 | Control register read value |
| access_rdata | output | 32 | Access register read value |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO line as seen at the pin |

## Verification
The bench sweeps the divider and measures the MDC period. A divider off by one, or one that ignored the factor of two, would show up as a wrong period. It sends write frames across edge addresses 0 and 31, and reads every register of a modelled PHY. A field placed in the wrong position or an opcode swapped would corrupt the captured frame, and late sampling would shift the read data by a bit. Three corner cases get their own checks. A second command written in mid-frame must not alter the fields or start a second frame. A read to an absent PHY must leave ACK clear. A command issued while disabled must wait without toggling MDC.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_BITS  = 64;
    localparam int IDX_W       = $clog2(FRAME_BITS);
    localparam int TA_FIRST    = 46;
    localparam int TA_SECOND   = 47;
    localparam int DATA_FIRST  = 48;
    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 5;

    localparam int BIT_GO      = 31;
    localparam int BIT_WRITE   = 30;
    localparam int BIT_ACK     = 29;
    localparam int BIT_IDLE    = 31;
    localparam int BIT_ENABLE  = 30;
    localparam int REG_LSB     = 21;
    localparam int PHY_LSB     = 16;

    localparam logic SEL_CTRL   = 1'b0;
    localparam logic SEL_ACCESS = 1'b1;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] regad;
        logic [ADDR_W-1:0] phyad;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0] op;
        logic [1:0] ta;
        logic [DATA_W-1:0] d;
        op = c.wr ? 2'b01 : 2'b10;
        ta = c.wr ? 2'b10 : 2'b11;
        d  = c.wr ? c.data : {DATA_W{1'b1}};
        return {32'hFFFF_FFFF, 2'b01, op, c.phyad, c.regad, ta, d};
    endfunction

endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = en && (cnt >= div);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: disabled clock stays low
    a_r2_mdc_low_when_off: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              start_req,
    input  mdio_cmd_t         cmd,
    input  logic              mdio_in,
    output logic              busy,
    output logic              done,
    output logic              ack,
    output logic [DATA_W-1:0] rd_data,
    output logic              mdio_o,
    output logic              mdio_oe
);
    eng_state_t            st;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W:0]        idx_nx;
    logic [FRAME_BITS-1:0] sh;
    logic                  is_wr;
    logic [DATA_W-1:0]     rd_q;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    assign busy    = (st == ENG_RUN);
    assign done    = busy && rise_tick && (idx == LAST_IDX);
    assign rd_data = {rd_q[DATA_W-2:0], mdio_in};
    assign idx_nx  = {1'b0, idx} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ENG_IDLE;
            idx     <= '0;
            sh      <= '0;
            is_wr   <= 1'b0;
            rd_q    <= '0;
            ack     <= 1'b0;
            mdio_o  <= 1'b0;
            mdio_oe <= 1'b0;
        end else begin
            case (st)
                ENG_IDLE: begin
                    if (start_req && fall_tick) begin
                        st      <= ENG_RUN;
                        idx     <= '0;
                        sh      <= build_frame(cmd);
                        mdio_o  <= build_frame(cmd)[FRAME_BITS-1];
                        mdio_oe <= 1'b1;
                        is_wr   <= cmd.wr;
                        ack     <= 1'b0;
                    end
                end
                ENG_RUN: begin
                    if (fall_tick) begin
                        idx     <= idx_nx[IDX_W-1:0];
                        sh      <= sh << 1;
                        mdio_o  <= sh[FRAME_BITS-2];
                        mdio_oe <= is_wr || (idx_nx < (IDX_W+1)'(TA_FIRST));
                    end
                    if (rise_tick) begin
                        if (!is_wr && idx == IDX_W'(TA_SECOND))
                            ack <= !mdio_in;
                        if (!is_wr && idx >= IDX_W'(DATA_FIRST))
                            rd_q <= rd_data;
                        if (idx == LAST_IDX) begin
                            st      <= ENG_IDLE;
                            mdio_oe <= 1'b0;
                        end
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // R10: driven value moves only on a falling clock edge
    a_r10_change_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(mdio_o) |-> $past(fall_tick));

    // R5: line released from turnaround onwards on reads
    a_r5_release_on_read: assert property (@(posedge clk) disable iff (rst)
        (busy && !is_wr && idx >= IDX_W'(TA_FIRST)) |-> !mdio_oe);

    // R3: frames only start on a request
    a_r3_start_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start_req));

endmodule

// File: rtl/mdio_user_regs.sv
module mdio_user_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_sel,
    input  logic [31:0]       bus_wdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic              eng_ack,
    input  logic [DATA_W-1:0] eng_rdata,
    output logic              en,
    output logic [DIV_W-1:0]  div,
    output logic              go,
    output mdio_cmd_t         cmd,
    output logic [31:0]       ctrl_rdata,
    output logic [31:0]       access_rdata
);
    logic ack_q;
    logic acc_wr;
    logic idle;

    assign acc_wr = bus_we && (bus_sel == SEL_ACCESS) && !go;
    assign idle   = !go && !eng_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            div   <= '0;
            go    <= 1'b0;
            cmd   <= '0;
            ack_q <= 1'b0;
        end else begin
            if (bus_we && bus_sel == SEL_CTRL) begin
                en  <= bus_wdata[BIT_ENABLE];
                div <= bus_wdata[DIV_W-1:0];
            end
            if (acc_wr) begin
                go        <= bus_wdata[BIT_GO];
                cmd.wr    <= bus_wdata[BIT_WRITE];
                cmd.regad <= bus_wdata[REG_LSB +: ADDR_W];
                cmd.phyad <= bus_wdata[PHY_LSB +: ADDR_W];
                cmd.data  <= bus_wdata[DATA_W-1:0];
                ack_q     <= 1'b0;
            end else if (eng_done) begin
                go <= 1'b0;
                if (!cmd.wr) begin
                    ack_q    <= eng_ack;
                    cmd.data <= eng_rdata;
                end
            end
        end
    end

    always_comb begin
        ctrl_rdata             = '0;
        ctrl_rdata[BIT_IDLE]   = idle;
        ctrl_rdata[BIT_ENABLE] = en;
        ctrl_rdata[DIV_W-1:0]  = div;
        access_rdata                      = '0;
        access_rdata[BIT_GO]              = go;
        access_rdata[BIT_WRITE]           = cmd.wr;
        access_rdata[BIT_ACK]             = ack_q;
        access_rdata[REG_LSB +: ADDR_W]   = cmd.regad;
        access_rdata[PHY_LSB +: ADDR_W]   = cmd.phyad;
        access_rdata[DATA_W-1:0]          = cmd.data;
    end

    // R7: busy-time writes leave the command untouched
    a_r7_ignore_busy_write: assert property (@(posedge clk) disable iff (rst)
        (go && bus_we && bus_sel == SEL_ACCESS && !eng_done) |=> $stable(cmd));

    // R3: completion drops GO
    a_r3_go_self_clears: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> !go);

    // R9: a finished write never reports an acknowledge
    a_r9_no_ack_on_write: assert property (@(posedge clk) disable iff (rst)
        (eng_done && cmd.wr) |=> !ack_q);

endmodule

// File: rtl/mdio_access_ctrl.sv
module mdio_access_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic        bus_sel,
    input  logic [31:0] bus_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] access_rdata,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic              en;
    logic [DIV_W-1:0]  div;
    logic              go;
    mdio_cmd_t         cmd;
    logic              rise_tick;
    logic              fall_tick;
    logic              busy;
    logic              done;
    logic              ack;
    logic [DATA_W-1:0] rd_data;
    logic              start_req;

    assign start_req = go && !busy;

    mdio_user_regs #(.DIV_W(DIV_W)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_we       (bus_we),
        .bus_sel      (bus_sel),
        .bus_wdata    (bus_wdata),
        .eng_busy     (busy),
        .eng_done     (done),
        .eng_ack      (ack),
        .eng_rdata    (rd_data),
        .en           (en),
        .div          (div),
        .go           (go),
        .cmd          (cmd),
        .ctrl_rdata   (ctrl_rdata),
        .access_rdata (access_rdata)
    );

    mdc_clock_gen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .div       (div),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .start_req (start_req),
        .cmd       (cmd),
        .mdio_in   (mdio_in),
        .busy      (busy),
        .done      (done),
        .ack       (ack),
        .rd_data   (rd_data),
        .mdio_o    (mdio_out),
        .mdio_oe   (mdio_oe)
    );

    // R8: no frame runs without the clock enabled
    a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (!en && !busy) |=> !busy);

endmodule

// File: tb/mdio_access_ctrl_test.sv
module mdio_access_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_sel = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] ctrl_rdata, access_rdata;
    logic        mdc, mdio_out, mdio_oe, mdio_in;

    localparam logic [4:0] RESP_PHY = 5'd9;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // PHY model
    logic phy_en = 1'b0;
    logic phy_val = 1'b1;
    assign mdio_in = mdio_oe ? mdio_out : (phy_en ? phy_val : 1'b1);

    mdio_access_ctrl uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .ctrl_rdata(ctrl_rdata),
        .access_rdata(access_rdata), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    function automatic logic [15:0] phy_word(input logic [4:0] r);
        return 16'h5A00 ^ {r, 6'd0, r} ^ {11'd0, r};
    endfunction

    // line monitor, sampled away from the active edge
    logic        mdc_q = 1'b0, line_q = 1'b1, oe_q = 1'b0, out_q = 1'b0;
    int          cap_cnt = 0;
    int          frames_seen = 0;
    logic [63:0] fr = '0, fr_oe = '0;
    logic [63:0] last_fr = '0, last_oe = '0;
    logic        rd_hit = 1'b0;
    logic [4:0]  rd_reg = '0;
    longint      cyc = 0, last_rise = 0, period = 0;
    int          bad_change = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst && (mdio_out !== out_q) && !(!mdc && mdc_q)) bad_change <= bad_change + 1;
        if (mdc && !mdc_q) begin
            period <= cyc - last_rise;
            last_rise <= cyc;
            if ((cap_cnt == 0 || cap_cnt == 64) && oe_q) begin
                fr = {63'd0, line_q}; fr_oe = {63'd0, oe_q}; cap_cnt = 1;
            end else if (cap_cnt > 0 && cap_cnt < 64) begin
                fr = {fr[62:0], line_q}; fr_oe = {fr_oe[62:0], oe_q};
                cap_cnt = cap_cnt + 1;
                if (cap_cnt == 46) begin
                    rd_hit = (fr[11:10] == 2'b10) && (fr[9:5] == RESP_PHY);
                    rd_reg = fr[4:0];
                end
                if (cap_cnt == 64) begin
                    last_fr <= fr; last_oe <= fr_oe;
                    frames_seen <= frames_seen + 1;
                end
            end
        end
        if (!mdc && mdc_q) begin
            if (cap_cnt == 47 && rd_hit) begin phy_en <= 1'b1; phy_val <= 1'b0; end
            else if (cap_cnt >= 48 && cap_cnt < 64 && rd_hit) begin
                phy_en <= 1'b1; phy_val <= phy_word(rd_reg)[63 - cap_cnt];
            end else begin phy_en <= 1'b0; phy_val <= 1'b1; end
        end
        mdc_q <= mdc; line_q <= mdio_in; oe_q <= mdio_oe; out_q <= mdio_out;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_test();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_test();
    end

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_sel = sel; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!access_rdata[31]) break;
        end
        repeat (4) @(negedge clk);
    endtask

    function automatic logic [31:0] cmd_word(input logic go, input logic w,
        input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        return {go, w, 4'd0, r, p, d};
    endfunction

    function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
        input logic [4:0] r, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b00), (w ? d : 16'd0)};
    endfunction

    initial begin
        logic [4:0]  pl[4];
        logic [4:0]  rl[3];
        int          f0;
        bit          mdc_seen;
        pl[0] = 5'd0; pl[1] = 5'd1; pl[2] = 5'd17; pl[3] = 5'd31;
        rl[0] = 5'd0; rl[1] = 5'd5; rl[2] = 5'd31;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 access reset", access_rdata, 0);
        chk("R1 ctrl reset", ctrl_rdata, 32'h8000_0000);
        chk("R1 pins reset", {mdc, mdio_oe}, 0);

        // R2 divider sweep
        for (int dv = 0; dv < 6; dv++) begin
            wr(1'b0, 32'h4000_0000 | dv);
            repeat (40) @(negedge clk);
            chk($sformatf("R2 mdc period div=%0d", dv), period, 2 * (dv + 1));
        end
        wr(1'b0, 32'h0000_0003);
        mdc_seen = 0;
        repeat (30) begin @(negedge clk); if (mdc) mdc_seen = 1; end
        chk("R2 mdc low when disabled", mdc_seen, 0);

        // R4 write frames
        wr(1'b0, 32'h4000_0000);
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 3; b++) begin
                logic [15:0] d;
                d = 16'hC3A5 ^ {pl[a], rl[b], 6'h15};
                f0 = frames_seen;
                wr(1'b1, cmd_word(1, 1, pl[a], rl[b], d));
                chk("R3 go set while busy", {access_rdata[31], ctrl_rdata[31]}, 2'b10);
                wait_idle();
                chk($sformatf("R4 write frame p=%0d r=%0d", pl[a], rl[b]), last_fr, exp_frame(1, pl[a], rl[b], d));
                chk("R4 oe all bits", last_oe, 64'hFFFF_FFFF_FFFF_FFFF);
                chk("R3 go clear and idle", {access_rdata[31], ctrl_rdata[31], frames_seen - f0}, {2'b01, 32'd1});
                chk("R9 write readback", access_rdata, cmd_word(0, 1, pl[a], rl[b], d));
            end

        // R5 R6 read sweep on responding PHY
        wr(1'b0, 32'h4000_0001);
        for (int r = 0; r < 32; r++) begin
            wr(1'b1, cmd_word(1, 0, RESP_PHY, 5'(r), 16'h0000));
            wait_idle();
            chk($sformatf("R5 read header r=%0d", r), {last_fr[63:18], 18'd0}, exp_frame(0, RESP_PHY, 5'(r), 0));
            chk("R5 read release", last_oe, 64'hFFFF_FFFF_FFFC_0000);
            chk($sformatf("R6 read data r=%0d", r), access_rdata, cmd_word(0, 0, RESP_PHY, 5'(r), phy_word(5'(r))) | 32'h2000_0000);
        end
        // R6 absent PHY
        wr(1'b1, cmd_word(1, 0, 5'd3, 5'd2, 16'h0));
        wait_idle();
        chk("R6 no ack absent phy", access_rdata[29], 0);
        // R9 accepted write clears ACK
        wr(1'b1, cmd_word(1, 0, RESP_PHY, 5'd4, 16'h0));
        wait_idle();
        chk("R6 ack set", access_rdata[29], 1);
        wr(1'b1, cmd_word(0, 1, 5'd2, 5'd2, 16'h1234));
        chk("R9 ack cleared", access_rdata, cmd_word(0, 1, 5'd2, 5'd2, 16'h1234));

        // R7 busy write ignored
        wr(1'b0, 32'h4000_0000);
        f0 = frames_seen;
        wr(1'b1, cmd_word(1, 1, 5'd6, 5'd7, 16'hBEEF));
        repeat (20) @(negedge clk);
        wr(1'b1, cmd_word(1, 0, 5'd25, 5'd26, 16'h0F0F));
        chk("R7 fields kept", access_rdata, cmd_word(1, 1, 5'd6, 5'd7, 16'hBEEF));
        wait_idle();
        repeat (300) @(negedge clk);
        chk("R7 frame unchanged", last_fr, exp_frame(1, 5'd6, 5'd7, 16'hBEEF));
        chk("R7 single frame", frames_seen - f0, 1);

        // R8 pending while disabled
        wr(1'b0, 32'h0000_0002);
        f0 = frames_seen;
        wr(1'b1, cmd_word(1, 1, 5'd12, 5'd19, 16'h8001));
        mdc_seen = 0;
        repeat (300) begin @(negedge clk); if (mdc) mdc_seen = 1; end
        chk("R8 pending state", {access_rdata[31], ctrl_rdata[31], mdc_seen, frames_seen - f0}, {3'b100, 32'd0});
        wr(1'b0, 32'h4000_0002);
        wait_idle();
        chk("R8 frame after enable", last_fr, exp_frame(1, 5'd12, 5'd19, 16'h8001));

        // R10
        chk("R10 mdio moves only on mdc fall", bad_change, 0);
        finish_test();
    end
endmodule